// File: doc/BRIEF.md
# PCI Target Transaction Sequencer

This block is the control core of a 32-bit PCI target. It watches the shared bus for the start of a transaction and captures the address and command on that clock. It then decides, through a fixed command table and the base-address hit lines, whether to claim the cycle. When it claims, it drives the three target handshake lines: device select, target ready and stop. It hands the back-end a latched, self-incrementing address, the latched command, the matching BAR and one strobe per completed data phase.

The back-end shapes each transaction through three request inputs: retry, target abort and disconnect. A build-time parameter inserts one idle clock between consecutive data phases of target reads, for a back-end that cannot source read data on every clock. Writes are never slowed.

The state register is one-hot, with ten states:

| State | Role |
|---|---|
| IDLE | Bus free; waits for a falling FRAME edge, which is the address phase. |
| DECODE | Command table and hit lookup. |
| CLAIM | Device select asserted; back-end requests are sampled here. |
| RDTURN | Extra bus turnaround clock before read data. |
| XFER | Target ready asserted. |
| WAITST | Inserted wait clock, one-wait read mode only. |
| DISC | Ready and stop both asserted, so data moves on the final phase. |
| HOLDSTOP | Stop held without ready, used by retry and after a disconnect. |
| ABORT | Stop asserted with device select released. |
| BUSY | Cycle not claimed; waits for the bus to go idle. |

The transitions are:
- IDLE→DECODE on the address phase.
- DECODE→CLAIM when the cycle is claimed, otherwise DECODE→BUSY.
- From CLAIM:
  - CLAIM→ABORT on an abort request.
  - CLAIM→HOLDSTOP on a retry request.
  - CLAIM→RDTURN for a read.
  - CLAIM→DISC or CLAIM→XFER for a write, depending on the disconnect request.
- RDTURN→DISC or RDTURN→XFER, depending on the disconnect request.
- WAITST→DISC or WAITST→XFER, depending on the disconnect request.
- From XFER, on a completed phase:
  - XFER→IDLE when FRAME is high.
  - XFER→DISC when disconnect is requested.
  - XFER→WAITST for a read in one-wait mode.
  - Otherwise it stays in XFER.
- DISC→IDLE when FRAME is high; otherwise DISC→HOLDSTOP after the phase completes.
- HOLDSTOP→IDLE and ABORT→IDLE when FRAME is high and IRDY is low.
- BUSY→IDLE when both FRAME and IRDY are high.

Top module: `pci_tgt_sequencer`

## Requirements
- R1: While reset is asserted and after its release, devsel_n, trdy_n and stop_n are all high and no strobe is active.
- R2: Command codes 0001, 0100, 0101, 1000, 1001 and 1101 on cbe_n[3:0] are never claimed: devsel_n stays high even with a BAR hit.
- R3: The non-configuration codes 0000, 0010, 0011, 0110, 0111, 1100, 1110 and 1111 are claimed only if at least one bar_hit bit is high during the decode clock. An unclaimed cycle leaves the block ready for the next transaction.
- R4: The configuration codes 1010 and 1011 are claimed only when idsel is high and ad_in[1:0] is 00 in the address clock, regardless of bar_hit.
- R5: Take the edge that samples the address as edge 0. devsel_n falls after edge 1. A write's first data phase completes at edge 3 and a read's at edge 4. Each later phase of a zero-wait burst completes one clock after the previous one.
- R6: addr_o holds the captured address during the first data phase and advances by 4 after each completed phase. cmd_o and bar_sel_o keep the captured command and hit until the next address phase.
- R7: A completed phase (target ready and IRDY both low) pulses wr_stb_o for commands with cbe_n[0]=1 and rd_stb_o for commands with cbe_n[0]=0, combinationally in that clock.
- R8: Once trdy_n is low, it stays low until IRDY completes the phase.
- R9: With ONE_WAIT=1, consecutive read phases complete two clocks apart; write phases still complete one clock apart.
- R10: A retry request in the claim clock gives stop_n low and devsel_n low with trdy_n high, and no data phase completes.
- R11: An abort request in the claim clock gives stop_n low with devsel_n and trdy_n high.
- R12: A disconnect request asserts stop_n together with trdy_n on the next data phase. That phase still transfers, and no further phase does.
- R13: stop_n stays low until FRAME is sampled high. The block returns to IDLE once the final phase completes with FRAME high, and claims the next transaction with normal timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Bus cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select for this device |
| cbe_n | input | 4 | Command in the address clock |
| ad_in | input | DW | Multiplexed address/data bus as seen by the target |
| bar_hit | input | NBAR | Per-BAR address match from the back-end decoder |
| be_retry | input | 1 | Back-end asks for a retry of this cycle |
| be_abort | input | 1 | Back-end asks for a target abort |
| be_disc | input | 1 | Back-end asks to stop after the next phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| addr_o | output | DW | Latched, incrementing transfer address |
| cmd_o | output | 4 | Latched command |
| bar_sel_o | output | NBAR | BAR hit latched in the decode clock |
| wr_stb_o | output | 1 | A write phase completes; data is on ad_in |
| rd_stb_o | output | 1 | A read phase completes; back-end advances |

## Verification
The hardest case to reach is a disconnect that lands on a phase that is itself completing while FRAME is still low. In that case, stop must be raised together with ready, exactly one more word must move, and stop must then be held alone until the initiator drops FRAME. The bench's initiator model drives the disconnect request only after it has seen a completed phase, so the request reaches the sequencer in the middle of a burst. A second delicate case is an initiator that keeps IRDY high while target ready is already low. The model stalls IRDY for a fixed number of clocks to check that ready is held and no strobe fires early.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;

    localparam int CMD_W = 4;

    typedef enum int unsigned {
        S_IDLE     = 0,
        S_DECODE   = 1,
        S_CLAIM    = 2,
        S_RDTURN   = 3,
        S_XFER     = 4,
        S_WAITST   = 5,
        S_DISC     = 6,
        S_HOLDSTOP = 7,
        S_ABORT    = 8,
        S_BUSY     = 9
    } st_idx_e;

    localparam int ST_N = 10;

endpackage

// File: rtl/tgt_cmd_filter.sv
module tgt_cmd_filter
    import tgt_seq_pkg::*;
#(
    parameter int NBAR = 3
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             cfg_sel,
    input  logic [NBAR-1:0]  bar_hit,
    output logic             claim,
    output logic             is_rd
);

    logic legal;
    logic cfg;

    always_comb begin
        unique case (cmd)
            4'b0000, 4'b0010, 4'b0011, 4'b0110,
            4'b0111, 4'b1100, 4'b1110, 4'b1111: begin
                legal = 1'b1;
                cfg   = 1'b0;
            end
            4'b1010, 4'b1011: begin
                legal = 1'b1;
                cfg   = 1'b1;
            end
            default: begin
                legal = 1'b0;
                cfg   = 1'b0;
            end
        endcase
    end

    // Every accepted read code has bit 0 clear, every write code has it set.
    assign is_rd = legal & ~cmd[0];
    assign claim = legal & (cfg ? cfg_sel : (|bar_hit));

endmodule

// File: rtl/tgt_addr_track.sv
module tgt_addr_track #(
    parameter int DW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= ad_in;
        end else if (adv) begin
            addr <= addr + DW'(STEP);
        end
    end

endmodule

// File: rtl/tgt_phase_fsm.sv
module tgt_phase_fsm
    import tgt_seq_pkg::*;
#(
    parameter bit ONE_WAIT = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_ph,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            claim,
    input  logic            is_rd,
    input  logic            be_retry,
    input  logic            be_abort,
    input  logic            be_disc,
    output logic [ST_N-1:0] st_q,
    output logic            devsel_n,
    output logic            trdy_n,
    output logic            stop_n,
    output logic            done
);

    logic [ST_N-1:0] st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q[S_IDLE] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = '0;
        unique case (1'b1)
            st_q[S_IDLE]: begin
                if (addr_ph) st_d[S_DECODE] = 1'b1;
                else         st_d[S_IDLE]   = 1'b1;
            end
            st_q[S_DECODE]: begin
                if (claim) st_d[S_CLAIM] = 1'b1;
                else       st_d[S_BUSY]  = 1'b1;
            end
            st_q[S_CLAIM]: begin
                if (be_abort)      st_d[S_ABORT]    = 1'b1;
                else if (be_retry) st_d[S_HOLDSTOP] = 1'b1;
                else if (is_rd)    st_d[S_RDTURN]   = 1'b1;
                else if (be_disc)  st_d[S_DISC]     = 1'b1;
                else               st_d[S_XFER]     = 1'b1;
            end
            st_q[S_RDTURN], st_q[S_WAITST]: begin
                if (be_disc) st_d[S_DISC] = 1'b1;
                else         st_d[S_XFER] = 1'b1;
            end
            st_q[S_XFER]: begin
                if (irdy_n)                  st_d[S_XFER]   = 1'b1;
                else if (frame_n)            st_d[S_IDLE]   = 1'b1;
                else if (be_disc)            st_d[S_DISC]   = 1'b1;
                else if (ONE_WAIT && is_rd)  st_d[S_WAITST] = 1'b1;
                else                         st_d[S_XFER]   = 1'b1;
            end
            st_q[S_DISC]: begin
                if (irdy_n)       st_d[S_DISC]     = 1'b1;
                else if (frame_n) st_d[S_IDLE]     = 1'b1;
                else              st_d[S_HOLDSTOP] = 1'b1;
            end
            st_q[S_HOLDSTOP]: begin
                if (frame_n && !irdy_n) st_d[S_IDLE]     = 1'b1;
                else                    st_d[S_HOLDSTOP] = 1'b1;
            end
            st_q[S_ABORT]: begin
                if (frame_n && !irdy_n) st_d[S_IDLE]  = 1'b1;
                else                    st_d[S_ABORT] = 1'b1;
            end
            st_q[S_BUSY]: begin
                if (frame_n && irdy_n) st_d[S_IDLE] = 1'b1;
                else                   st_d[S_BUSY] = 1'b1;
            end
            default: st_d[S_IDLE] = 1'b1;
        endcase
    end

    always_comb begin
        devsel_n = ~(st_q[S_CLAIM] | st_q[S_RDTURN] | st_q[S_XFER] |
                     st_q[S_WAITST] | st_q[S_DISC] | st_q[S_HOLDSTOP]);
        trdy_n   = ~(st_q[S_XFER] | st_q[S_DISC]);
        stop_n   = ~(st_q[S_DISC] | st_q[S_HOLDSTOP] | st_q[S_ABORT]);
        done     = (st_q[S_XFER] | st_q[S_DISC]) & ~irdy_n;
    end

endmodule

// File: rtl/pci_tgt_sequencer.sv
module pci_tgt_sequencer
    import tgt_seq_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NBAR     = 3,
    parameter bit ONE_WAIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             idsel,
    input  logic [CMD_W-1:0] cbe_n,
    input  logic [DW-1:0]    ad_in,
    input  logic [NBAR-1:0]  bar_hit,
    input  logic             be_retry,
    input  logic             be_abort,
    input  logic             be_disc,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic [DW-1:0]    addr_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic [NBAR-1:0]  bar_sel_o,
    output logic             wr_stb_o,
    output logic             rd_stb_o
);

    localparam int STEP = DW / 8;

    logic [ST_N-1:0] st_q;
    logic            frame_prev;
    logic            addr_ph;
    logic            load;
    logic            cfg_sel_q;
    logic            claim;
    logic            is_rd;
    logic            done;

    assign addr_ph = ~frame_n & frame_prev;
    assign load    = st_q[S_IDLE] & addr_ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_prev <= 1'b1;
            cmd_o      <= '0;
            cfg_sel_q  <= 1'b0;
            bar_sel_o  <= '0;
        end else begin
            frame_prev <= frame_n;
            if (load) begin
                cmd_o     <= cbe_n;
                cfg_sel_q <= idsel & (ad_in[1:0] == 2'b00);
            end
            if (st_q[S_DECODE]) begin
                bar_sel_o <= bar_hit;
            end
        end
    end

    tgt_cmd_filter #(.NBAR(NBAR)) filt_i (
        .cmd     (cmd_o),
        .cfg_sel (cfg_sel_q),
        .bar_hit (bar_hit),
        .claim   (claim),
        .is_rd   (is_rd)
    );

    tgt_addr_track #(.DW(DW), .STEP(STEP)) addr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (done),
        .ad_in (ad_in),
        .addr  (addr_o)
    );

    tgt_phase_fsm #(.ONE_WAIT(ONE_WAIT)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_ph  (addr_ph),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .claim    (claim),
        .is_rd    (is_rd),
        .be_retry (be_retry),
        .be_abort (be_abort),
        .be_disc  (be_disc),
        .st_q     (st_q),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .done     (done)
    );

    assign wr_stb_o = done & ~is_rd;
    assign rd_stb_o = done & is_rd;

endmodule

// File: rtl/tgt_seq_chk.sv
module tgt_seq_chk
    import tgt_seq_pkg::*;
#(
    parameter int DW       = 32,
    parameter bit ONE_WAIT = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             be_disc,
    input logic             devsel_n,
    input logic             trdy_n,
    input logic             stop_n,
    input logic [DW-1:0]    addr_o,
    input logic [CMD_W-1:0] cmd_o,
    input logic             wr_stb_o,
    input logic             rd_stb_o,
    input logic [ST_N-1:0]  st_q
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (devsel_n && trdy_n && stop_n && !wr_stb_o && !rd_stb_o)
                else $error("handshake lines active during reset");
        end
    end

    p_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1)
        else $error("state register not one-hot");

    p_ignore_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[S_DECODE] && (cmd_o inside {4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1101})
        |=> devsel_n)
        else $error("ignored command claimed");

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o || rd_stb_o) && !frame_n |=> addr_o == $past(addr_o) + DW'(DW / 8))
        else $error("address did not advance by one word");

    p_trdy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n && irdy_n |=> !trdy_n)
        else $error("target ready dropped before phase completed");

    p_read_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o && !frame_n && !be_disc |=> trdy_n == ONE_WAIT)
        else $error("read wait insertion wrong");

    p_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n && !devsel_n && trdy_n && !frame_n |=> !devsel_n && !stop_n)
        else $error("retry handshake released early");

    p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n && devsel_n |-> trdy_n)
        else $error("abort with target ready");

    p_stop_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n && !frame_n |=> !stop_n)
        else $error("stop released while frame still low");

endmodule

bind pci_tgt_sequencer tgt_seq_chk #(.DW(DW), .ONE_WAIT(ONE_WAIT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .be_disc  (be_disc),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .addr_o   (addr_o),
    .cmd_o    (cmd_o),
    .wr_stb_o (wr_stb_o),
    .rd_stb_o (rd_stb_o),
    .st_q     (st_q)
);

// File: tb/pci_tgt_sequencer_tb_top.sv
`timescale 1ns/1ps
module pci_tgt_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [3:0]  cbe_n = 4'h0;
    logic [31:0] ad_in = '0;
    logic [2:0]  bar_hit = '0;
    logic        be_retry = 1'b0;
    logic        be_abort = 1'b0;
    logic        be_disc = 1'b0;

    logic        z_devsel, z_trdy, z_stop, z_wr, z_rd;
    logic [31:0] z_addr;
    logic [3:0]  z_cmd;
    logic [2:0]  z_bar;
    logic        w_devsel, w_trdy, w_stop, w_wr, w_rd;
    logic [31:0] w_addr;
    logic [3:0]  w_cmd;
    logic [2:0]  w_bar;

    always #2 clk = ~clk;

    pci_tgt_sequencer #(.DW(32), .NBAR(3), .ONE_WAIT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .cbe_n(cbe_n), .ad_in(ad_in), .bar_hit(bar_hit), .be_retry(be_retry),
        .be_abort(be_abort), .be_disc(be_disc), .devsel_n(z_devsel), .trdy_n(z_trdy),
        .stop_n(z_stop), .addr_o(z_addr), .cmd_o(z_cmd), .bar_sel_o(z_bar),
        .wr_stb_o(z_wr), .rd_stb_o(z_rd)
    );

    pci_tgt_sequencer #(.DW(32), .NBAR(3), .ONE_WAIT(1'b1)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .cbe_n(cbe_n), .ad_in(ad_in), .bar_hit(bar_hit), .be_retry(be_retry),
        .be_abort(be_abort), .be_disc(be_disc), .devsel_n(w_devsel), .trdy_n(w_trdy),
        .stop_n(w_stop), .addr_o(w_addr), .cmd_o(w_cmd), .bar_sel_o(w_bar),
        .wr_stb_o(w_wr), .rd_stb_o(w_rd)
    );

    bit use_w = 1'b0;
    wire        m_devsel = use_w ? w_devsel : z_devsel;
    wire        m_trdy   = use_w ? w_trdy   : z_trdy;
    wire        m_stop   = use_w ? w_stop   : z_stop;
    wire        m_wr     = use_w ? w_wr     : z_wr;
    wire        m_rd     = use_w ? w_rd     : z_rd;
    wire [31:0] m_addr   = use_w ? w_addr   : z_addr;
    wire [3:0]  m_cmd    = use_w ? w_cmd    : z_cmd;
    wire [2:0]  m_bar    = use_w ? w_bar    : z_bar;

    int  n_chk = 0;
    int  n_err = 0;
    bit  ended = 1'b0;

    // results of the last transaction
    int  claimed, aborted, retried, ndone, trdy_cnt, wr_cnt, rd_cnt, addr_bad, end_cyc;
    int  ph_cyc[8];
    int  irdy_hold = 0;
    bit  disc_en = 1'b0;
    int  disc_at = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // Initiator model: address phase, then data phases until termination.
    task automatic xact(input logic [3:0] cmd, input logic [31:0] adr, input logic idv, input int nph);
        int  cyc = 0;
        bit  saw_stop = 1'b0;
        bit  fhi = 1'b0;
        bit  fin = 1'b0;
        claimed = 0; aborted = 0; retried = 0; ndone = 0; trdy_cnt = 0;
        wr_cnt = 0; rd_cnt = 0; addr_bad = 0; end_cyc = 0;
        for (int i = 0; i < 8; i++) ph_cyc[i] = 0;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = adr; cbe_n = cmd; idsel = idv;
        while (!fin && cyc < 40) begin
            @(negedge clk);
            cyc++;
            idsel = 1'b0;
            ad_in = 32'hD000_0000 + 32'(cyc);
            cbe_n = 4'h0;
            irdy_n = (ndone == 0 && cyc <= irdy_hold) ? 1'b1 : 1'b0;
            if (!irdy_n && ((ndone >= nph - 1) || saw_stop || (cyc >= 4 && claimed == 0)))
                fhi = 1'b1;
            frame_n = fhi;
            #1;
            if (!m_devsel) claimed = 1;
            if (!m_stop && m_devsel) aborted = 1;
            if (!m_stop && !m_devsel && m_trdy) retried = 1;
            if (!m_stop) saw_stop = 1'b1;
            if (!m_trdy) trdy_cnt++;
            if (m_wr) wr_cnt++;
            if (m_rd) rd_cnt++;
            if (!m_trdy && !irdy_n) begin
                if (ndone < 8) ph_cyc[ndone] = cyc;
                if (m_addr != adr + 32'(4 * ndone)) addr_bad++;
                ndone++;
            end
            be_disc = disc_en && (ndone >= disc_at);
            if (frame_n && !irdy_n && (!m_trdy || !m_stop)) fin = 1'b1;
            if (claimed == 0 && cyc >= 4 && frame_n) fin = 1'b1;
            if (fin) end_cyc = cyc;
        end
        @(negedge clk);
        irdy_n = 1'b1; frame_n = 1'b1; be_disc = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1", "devsel_n in reset", z_devsel, 1);
        chk("R1", "trdy_n in reset", z_trdy, 1);
        chk("R1", "stop_n in reset", z_stop, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "handshake lines after reset", {z_devsel, z_trdy, z_stop, z_wr, z_rd}, 5'b11100);
    endtask

    task automatic t_write_burst();
        use_w = 1'b0; bar_hit = 3'b010;
        xact(4'b0111, 32'h0000_0100, 1'b0, 4);
        chk("R5", "write phase 0 edge", ph_cyc[0], 3);
        chk("R5", "write phase 3 edge", ph_cyc[3], 6);
        chk("R6", "burst address errors", addr_bad, 0);
        chk("R6", "latched command", m_cmd, 4'b0111);
        chk("R6", "latched bar", m_bar, 3'b010);
        chk("R7", "write strobes", wr_cnt, 4);
        chk("R7", "read strobes on write", rd_cnt, 0);
    endtask

    task automatic t_read_burst();
        use_w = 1'b0; bar_hit = 3'b001;
        xact(4'b0110, 32'h0000_2000, 1'b0, 3);
        chk("R5", "read phase 0 edge", ph_cyc[0], 4);
        chk("R5", "read phase 2 edge", ph_cyc[2], 6);
        chk("R7", "read strobes", rd_cnt, 3);
        chk("R7", "write strobes on read", wr_cnt, 0);
        chk("R6", "read address errors", addr_bad, 0);
    endtask

    task automatic t_one_wait();
        use_w = 1'b1; bar_hit = 3'b100;
        xact(4'b1100, 32'h0000_3000, 1'b0, 3);
        chk("R9", "one-wait read phase 1 edge", ph_cyc[1], 6);
        chk("R9", "one-wait read phase 2 edge", ph_cyc[2], 8);
        xact(4'b0111, 32'h0000_3100, 1'b0, 3);
        chk("R9", "one-wait write phase 2 edge", ph_cyc[2], 5);
        use_w = 1'b0;
    endtask

    task automatic t_ignored();
        logic [3:0] codes[6] = '{4'b0001, 4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b1101};
        use_w = 1'b0; bar_hit = 3'b111;
        foreach (codes[k]) begin
            xact(codes[k], 32'h0000_0040, 1'b0, 1);
            chk("R2", $sformatf("claim of code %b", codes[k]), claimed, 0);
        end
    endtask

    task automatic t_hit_rules();
        use_w = 1'b0; bar_hit = 3'b000;
        xact(4'b0110, 32'h0000_0200, 1'b0, 1);
        chk("R3", "claim without bar hit", claimed, 0);
        bar_hit = 3'b001;
        xact(4'b0011, 32'h0000_0300, 1'b0, 1);
        chk("R3", "io write claimed after unclaimed cycle", claimed, 1);
        chk("R3", "io write edge", ph_cyc[0], 3);
        xact(4'b0000, 32'h0000_0000, 1'b0, 1);
        chk("R3", "interrupt acknowledge claimed", claimed, 1);
    endtask

    task automatic t_config();
        use_w = 1'b0; bar_hit = 3'b000;
        xact(4'b1010, 32'h0000_0004, 1'b1, 1);
        chk("R4", "config read with idsel", claimed, 1);
        chk("R4", "config read strobe", rd_cnt, 1);
        xact(4'b1011, 32'h0000_0008, 1'b0, 1);
        chk("R4", "config write without idsel", claimed, 0);
        bar_hit = 3'b111;
        xact(4'b1011, 32'h0000_0009, 1'b1, 1);
        chk("R4", "config with ad[1:0]=01", claimed, 0);
    endtask

    task automatic t_trdy_hold();
        use_w = 1'b0; bar_hit = 3'b001; irdy_hold = 5;
        xact(4'b0111, 32'h0000_0500, 1'b0, 1);
        chk("R8", "cycles with trdy low", trdy_cnt, 4);
        chk("R8", "completion edge", ph_cyc[0], 6);
        chk("R8", "single strobe", wr_cnt, 1);
        irdy_hold = 0;
    endtask

    task automatic t_retry();
        use_w = 1'b0; bar_hit = 3'b001; be_retry = 1'b1;
        xact(4'b0110, 32'h0000_0600, 1'b0, 1);
        be_retry = 1'b0;
        chk("R10", "retry seen", retried, 1);
        chk("R10", "phases on retry", ndone, 0);
        chk("R10", "strobes on retry", wr_cnt + rd_cnt, 0);
    endtask

    task automatic t_abort();
        use_w = 1'b0; bar_hit = 3'b001; be_abort = 1'b1;
        xact(4'b0111, 32'h0000_0700, 1'b0, 1);
        be_abort = 1'b0;
        chk("R11", "abort seen", aborted, 1);
        chk("R11", "phases on abort", ndone, 0);
        chk("R11", "trdy cycles on abort", trdy_cnt, 0);
    endtask

    task automatic t_disconnect();
        use_w = 1'b0; bar_hit = 3'b001; disc_en = 1'b1; disc_at = 1;
        xact(4'b0111, 32'h0000_0800, 1'b0, 4);
        disc_en = 1'b0;
        chk("R12", "phases moved before disconnect", ndone, 2);
        chk("R12", "disconnect phase edge", ph_cyc[1], 4);
        chk("R13", "stop held to frame release", end_cyc, 5);
        chk("R13", "stop without trdy after disconnect", retried, 1);
        xact(4'b0111, 32'h0000_0900, 1'b0, 1);
        chk("R13", "next cycle after termination", ph_cyc[0], 3);
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_write_burst();
        t_read_burst();
        t_one_wait();
        t_ignored();
        t_hit_rules();
        t_config();
        t_trdy_hold();
        t_retry();
        t_abort();
        t_disconnect();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule